// File: doc/BRIEF.md
# Single-Wire Bus Link Monitor

This block listens, without ever driving, to a single-wire open-drain bus on which a host and one or more devices talk by pulling the line low. The raw line is brought into the clock domain through two flip-flops. A counter then times every low phase and every high phase in clock ticks. When a low phase ends, the monitor sorts it by its length into one of four classes: a standard-speed reset, an overdrive reset, a read/write time slot that carries a bit, or an erroneous pulse. After a reset it opens a presence window and reports whether a device answered in time. It also flags gaps between pulses that are too short.

All thresholds are given in microseconds. `TICKS_PER_US` turns them into clock counts. At standard speed the reset lies between 480 and 960 µs. A slot is shorter than 120 µs. A low time under 15 µs reads as a 1, and the recovery minimum is 1 µs. Overdrive speed uses shorter windows. No command decoding takes place here, so an outside strobe switches overdrive speed on. Results come out as one-cycle strobes: an event code, a decoded bit, an overdrive-exit pulse and three warnings. The `overdrive` level output shows the current speed.

Top module: `owire_monitor`

## Requirements
- R1: After reset every strobe output is low, `evt_code` is 0 and `overdrive` is 0. Results appear on the third clock edge after the line change that ends a phase.
- R2: A low pulse shorter than the slot maximum for the current speed (and not a reset) produces one `bit_valid` strobe. `bit_value` is 1 when the low time is below the low-read maximum and 0 otherwise.
- R3: A slot whose low time is below the low-read minimum is still decoded. `warn_low_short` pulses together with `bit_valid`.
- R4: A low pulse of at least the standard reset minimum is a standard reset at either speed. It is reported as `evt_code` 1.
- R5: A standard reset longer than the standard reset maximum also pulses `warn_rst_long`.
- R6: A standard reset clears `overdrive`. If `overdrive` was set, `od_exit` pulses with the reset event.
- R7: In overdrive mode, a low pulse of at least the overdrive reset minimum and below the overdrive reset maximum is reported as `evt_code` 2. `overdrive` stays set.
- R8: A low pulse that fits no class is reported as `evt_code` 3, and the monitor returns to idle. The next slot then decodes normally.
- R9: After either reset, a falling edge within the presence-high maximum ticks (inclusive) of the reset's rising edge reports `evt_code` 4, and that device low pulse is not decoded as a slot. If no such edge comes, `evt_code` 5 is reported and the monitor returns to idle.
- R10: Once a rising edge has been seen, a falling edge that follows a high time below the recovery minimum pulses `warn_rec_short`.
- R11: A one-cycle `od_enter` strobe sets `overdrive`. The overdrive flag selects which speed's thresholds apply.
- R12: The width counter saturates instead of wrapping, so a very long low pulse is still a standard reset with `warn_rst_long`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Raw bus line level (asynchronous) |
| od_enter | input | 1 | Strobe: switch to overdrive speed |
| evt_valid | output | 1 | Event strobe |
| evt_code | output | 3 | 1 std reset, 2 overdrive reset, 3 error, 4 presence, 5 no presence |
| bit_valid | output | 1 | Decoded slot strobe |
| bit_value | output | 1 | Decoded slot bit |
| overdrive | output | 1 | Overdrive speed active |
| od_exit | output | 1 | Strobe: overdrive left by a standard reset |
| warn_rec_short | output | 1 | Strobe: recovery time too short |
| warn_rst_long | output | 1 | Strobe: reset pulse too long |
| warn_low_short | output | 1 | Strobe: slot low time too short |

## Verification
A stuck or wrong overdrive flag makes the monitor use the wrong thresholds. The next slot or reset is then sorted into the wrong class, and this shows on `bit_value` or `evt_code` three cycles after that pulse's rising edge. A state machine left in the presence states swallows the following low pulse: no `bit_valid` appears, or an unexpected code 4 or 5 shows up. A wrapped width counter turns an over-long reset into an error event. The bench sweeps pulse widths across each threshold at both speeds, so each of these faults shows within the pulse that triggers it.

// File: rtl/owire_monitor.sv
module owire_monitor #(
  parameter int TICKS_PER_US   = 100,
  parameter int STD_RST_MIN_US = 480,
  parameter int STD_RST_MAX_US = 960,
  parameter int STD_SLOT_US    = 120,
  parameter int STD_LOWR_MIN_US = 1,
  parameter int STD_LOWR_MAX_US = 15,
  parameter int STD_REC_US     = 1,
  parameter int STD_PDH_US     = 60,
  parameter int OD_RST_MIN_US  = 48,
  parameter int OD_RST_MAX_US  = 80,
  parameter int OD_SLOT_US     = 16,
  parameter int OD_LOWR_MIN_US = 1,
  parameter int OD_LOWR_MAX_US = 2,
  parameter int OD_REC_US      = 1,
  parameter int OD_PDH_US      = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_in,
  input  logic       od_enter,
  output logic       evt_valid,
  output logic [2:0] evt_code,
  output logic       bit_valid,
  output logic       bit_value,
  output logic       overdrive,
  output logic       od_exit,
  output logic       warn_rec_short,
  output logic       warn_rst_long,
  output logic       warn_low_short
);
  localparam logic [31:0] STD_RST_MIN  = 32'(STD_RST_MIN_US * TICKS_PER_US);
  localparam logic [31:0] STD_RST_MAX  = 32'(STD_RST_MAX_US * TICKS_PER_US);
  localparam logic [31:0] STD_SLOT     = 32'(STD_SLOT_US * TICKS_PER_US);
  localparam logic [31:0] STD_LOWR_MIN = 32'(STD_LOWR_MIN_US * TICKS_PER_US);
  localparam logic [31:0] STD_LOWR_MAX = 32'(STD_LOWR_MAX_US * TICKS_PER_US);
  localparam logic [31:0] STD_REC      = 32'(STD_REC_US * TICKS_PER_US);
  localparam logic [31:0] STD_PDH      = 32'(STD_PDH_US * TICKS_PER_US);
  localparam logic [31:0] OD_RST_MIN   = 32'(OD_RST_MIN_US * TICKS_PER_US);
  localparam logic [31:0] OD_RST_MAX   = 32'(OD_RST_MAX_US * TICKS_PER_US);
  localparam logic [31:0] OD_SLOT      = 32'(OD_SLOT_US * TICKS_PER_US);
  localparam logic [31:0] OD_LOWR_MIN  = 32'(OD_LOWR_MIN_US * TICKS_PER_US);
  localparam logic [31:0] OD_LOWR_MAX  = 32'(OD_LOWR_MAX_US * TICKS_PER_US);
  localparam logic [31:0] OD_REC       = 32'(OD_REC_US * TICKS_PER_US);
  localparam logic [31:0] OD_PDH       = 32'(OD_PDH_US * TICKS_PER_US);
  localparam int CW = $clog2(STD_RST_MAX_US * TICKS_PER_US + 2) + 1;

  localparam logic [2:0] EV_RST_STD = 3'd1;
  localparam logic [2:0] EV_RST_OD  = 3'd2;
  localparam logic [2:0] EV_ERROR   = 3'd3;
  localparam logic [2:0] EV_PRESENT = 3'd4;
  localparam logic [2:0] EV_ABSENT  = 3'd5;

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_PRES, ST_PRES_LOW} state_t;
  state_t state;

  logic [1:0]    sync;
  logic          prev;
  logic [CW-1:0] cnt;
  logic          seen_rise;

  wire line = sync[1];
  wire fall = prev & ~line;
  wire rise = ~prev & line;
  wire [31:0] width = 32'(cnt);

  wire [31:0] slot_max = overdrive ? OD_SLOT     : STD_SLOT;
  wire [31:0] lowr_min = overdrive ? OD_LOWR_MIN : STD_LOWR_MIN;
  wire [31:0] lowr_max = overdrive ? OD_LOWR_MAX : STD_LOWR_MAX;
  wire [31:0] rec_min  = overdrive ? OD_REC      : STD_REC;
  wire [31:0] pdh_max  = overdrive ? OD_PDH      : STD_PDH;

  wire is_std_rst = width >= STD_RST_MIN;
  wire is_od_rst  = overdrive && width >= OD_RST_MIN && width < OD_RST_MAX;
  wire std_rst_now = (state == ST_LOW) && rise && is_std_rst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync <= 2'b11;
      prev <= 1'b1;
    end else begin
      sync <= {sync[0], line_in};
      prev <= sync[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (fall || rise)
      cnt <= CW'(1);
    else if (cnt != '1)
      cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state          <= ST_IDLE;
      seen_rise      <= 1'b0;
      overdrive      <= 1'b0;
      evt_valid      <= 1'b0;
      evt_code       <= 3'd0;
      bit_valid      <= 1'b0;
      bit_value      <= 1'b0;
      od_exit        <= 1'b0;
      warn_rec_short <= 1'b0;
      warn_rst_long  <= 1'b0;
      warn_low_short <= 1'b0;
    end else begin
      evt_valid      <= 1'b0;
      bit_valid      <= 1'b0;
      od_exit        <= 1'b0;
      warn_rec_short <= 1'b0;
      warn_rst_long  <= 1'b0;
      warn_low_short <= 1'b0;
      if (rise) seen_rise <= 1'b1;

      if (std_rst_now) begin
        overdrive <= 1'b0;
        od_exit   <= overdrive;
      end else if (od_enter) begin
        overdrive <= 1'b1;
      end

      case (state)
        ST_IDLE: if (fall) begin
          state          <= ST_LOW;
          warn_rec_short <= seen_rise && (width < rec_min);
        end
        ST_LOW: if (rise) begin
          if (is_std_rst) begin
            evt_valid     <= 1'b1;
            evt_code      <= EV_RST_STD;
            warn_rst_long <= width > STD_RST_MAX;
            state         <= ST_PRES;
          end else if (is_od_rst) begin
            evt_valid <= 1'b1;
            evt_code  <= EV_RST_OD;
            state     <= ST_PRES;
          end else if (width < slot_max) begin
            bit_valid      <= 1'b1;
            bit_value      <= width < lowr_max;
            warn_low_short <= width < lowr_min;
            state          <= ST_IDLE;
          end else begin
            evt_valid <= 1'b1;
            evt_code  <= EV_ERROR;
            state     <= ST_IDLE;
          end
        end
        ST_PRES: if (fall) begin
          evt_valid <= 1'b1;
          evt_code  <= EV_PRESENT;
          state     <= ST_PRES_LOW;
        end else if (width > pdh_max) begin
          evt_valid <= 1'b1;
          evt_code  <= EV_ABSENT;
          state     <= ST_IDLE;
        end
        ST_PRES_LOW: if (rise) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/owire_monitor_chk.sv
module owire_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       evt_valid,
  input logic [2:0] evt_code,
  input logic       bit_valid,
  input logic       bit_value,
  input logic       overdrive,
  input logic       od_exit,
  input logic       warn_rst_long,
  input logic       warn_low_short
);
  assert_bit_not_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_valid && evt_valid));
  assert_short_has_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    warn_low_short |-> bit_valid && bit_value);
  assert_long_is_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    warn_rst_long |-> evt_valid && evt_code == 3'd1);
  assert_exit_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    od_exit |-> !overdrive && $past(overdrive));
  assert_exit_with_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    od_exit |-> evt_valid && evt_code == 3'd1);
  assert_od_reset_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_code == 3'd2) |-> overdrive && $past(overdrive));
  assert_code_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (evt_code >= 3'd1 && evt_code <= 3'd5));
endmodule

bind owire_monitor owire_monitor_chk chk_i (.*);

// File: tb/owire_monitor_test.sv
module owire_monitor_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_in = 1'b1;
  logic od_enter = 1'b0;
  logic evt_valid, bit_valid, bit_value, overdrive, od_exit;
  logic warn_rec_short, warn_rst_long, warn_low_short;
  logic [2:0] evt_code;

  always #5 clk = ~clk;

  owire_monitor #(.TICKS_PER_US(2)) uut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .od_enter(od_enter),
    .evt_valid(evt_valid), .evt_code(evt_code), .bit_valid(bit_valid),
    .bit_value(bit_value), .overdrive(overdrive), .od_exit(od_exit),
    .warn_rec_short(warn_rec_short), .warn_rst_long(warn_rst_long),
    .warn_low_short(warn_low_short));

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] seen;
  int nbit, nshort, nlong, nexit, nrec;
  logic lastbit;

  always @(negedge clk) if (rst_n) begin
    if (evt_valid) seen[evt_code] = 1'b1;
    if (bit_valid) begin nbit = nbit + 1; lastbit = bit_value; end
    if (warn_low_short) nshort = nshort + 1;
    if (warn_rst_long) nlong = nlong + 1;
    if (od_exit) nexit = nexit + 1;
    if (warn_rec_short) nrec = nrec + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clr();
    @(posedge clk);
    seen = 0; nbit = 0; nshort = 0; nlong = 0; nexit = 0; nrec = 0; lastbit = 0;
    @(negedge clk);
  endtask

  task automatic low(input int n);
    line_in = 1'b0;
    repeat (n) @(negedge clk);
    line_in = 1'b1;
  endtask

  task automatic high(input int n);
    repeat (n) @(negedge clk);
  endtask

  typedef struct packed {
    logic od; logic [15:0] w; logic [7:0] mask;
    logic bv; logic bval; logic sh; logic lg; logic ex; logic oda;
  } vec_t;
  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 16'd5,    8'd0,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 16'd2,    8'd0,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 16'd29,   8'd0,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 16'd30,   8'd0,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 16'd1,    8'd0,  1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b0, 16'd239,  8'd0,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 16'd240,  8'd8,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 16'd500,  8'd8,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 16'd960,  8'd34, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 16'd1921, 8'd34, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b1, 16'd3,    8'd0,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    '{1'b1, 16'd4,    8'd0,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{1'b1, 16'd1,    8'd0,  1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    '{1'b1, 16'd31,   8'd0,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{1'b1, 16'd32,   8'd8,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{1'b1, 16'd96,   8'd36, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{1'b1, 16'd160,  8'd8,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{1'b1, 16'd960,  8'd34, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}
  };

  initial begin
    seen = 0; nbit = 0; nshort = 0; nlong = 0; nexit = 0; nrec = 0; lastbit = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(!evt_valid && !bit_valid && !od_exit, "R1 strobes", int'(evt_valid | bit_valid | od_exit), 0);
    chk(evt_code == 3'd0, "R1 code", int'(evt_code), 0);
    chk(!overdrive, "R1 overdrive", int'(overdrive), 0);
    chk(!warn_rec_short && !warn_rst_long && !warn_low_short, "R1 warnings",
        int'(warn_rec_short | warn_rst_long | warn_low_short), 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].od) begin
        od_enter = 1'b1; @(negedge clk); od_enter = 1'b0;
        repeat (2) @(negedge clk);
        chk(overdrive == 1'b1, "R11 od_enter", int'(overdrive), 1);
      end
      clr();
      low(int'(VEC[i].w));
      high(300);
      chk(seen == VEC[i].mask, "R4 R7 R8 R9 events", int'(seen), int'(VEC[i].mask));
      chk(nbit == int'(VEC[i].bv), "R2 bit count", nbit, int'(VEC[i].bv));
      if (VEC[i].bv) chk(lastbit == VEC[i].bval, "R2 bit value", int'(lastbit), int'(VEC[i].bval));
      chk(nshort == int'(VEC[i].sh), "R3 low short", nshort, int'(VEC[i].sh));
      chk(nlong == int'(VEC[i].lg), "R5 reset long", nlong, int'(VEC[i].lg));
      chk(nexit == int'(VEC[i].ex), "R6 od exit", nexit, int'(VEC[i].ex));
      chk(overdrive == VEC[i].oda, "R6 R7 R11 overdrive after", int'(overdrive), int'(VEC[i].oda));
    end

    // R9 presence answered within window, device pulse not decoded
    clr(); low(1000); high(10); low(100); high(300);
    chk(seen == 8'd18, "R9 presence", int'(seen), 18);
    chk(nbit == 0, "R9 no slot", nbit, 0);
    // R9 boundary: fall exactly at the window limit
    clr(); low(1000); high(120); low(100); high(300);
    chk(seen == 8'd18, "R9 presence edge", int'(seen), 18);
    // R9 timeout then the late low pulse decodes as a slot
    clr(); low(1000); high(130); low(100); high(300);
    chk(seen == 8'd34, "R9 absent", int'(seen), 34);
    chk(nbit == 1 && lastbit == 1'b0, "R9 late slot", nbit, 1);

    // R10 recovery too short, then just long enough
    clr(); low(5); high(1); low(5); high(300);
    chk(nrec == 1, "R10 short gap", nrec, 1);
    chk(nbit == 2, "R10 bits", nbit, 2);
    clr(); low(5); high(2); low(5); high(300);
    chk(nrec == 0, "R10 min gap", nrec, 0);

    // R12 saturating counter on a very long pulse
    clr(); low(5000); high(300);
    chk(seen == 8'd34, "R12 saturated reset", int'(seen), 34);
    chk(nlong == 1, "R12 long warning", nlong, 1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule